// File: doc/BRIEF.md
# DDR2 Device-Side Command State Machine

This block is a synthesizable behavioural model of the memory end of a DDR2 SDRAM link. On every rising clock edge it samples the active-low command strobes, the clock enable, the bank bits and the 13-bit multiplexed address. It turns them into commands and moves a device state machine through power-up, mode programming, refresh, row opening, burst reads and writes, precharge and active power-down. Its purpose is to stand in for a memory part when a controller is verified or co-designed. Double-rate I/O, DLL and driver calibration timing and real cell behaviour are left out.

A small internal array backs the data. Rows are folded onto a few index bits and columns are truncated, so a real access pattern lands on a compact store. Write data enters on a 16-bit input with one mask bit per byte lane. Read data leaves on a 16-bit output with an enable that stands for the tristate control. The mode register cannot be read back. Its burst length, burst order and CAS latency fields take effect on later accesses.

Top module: `ddr2_device_fsm`

## Requirements
- R1: With `cs_n` high the command is a no-op whatever the strobes show. With `cs_n` low, `{ras_n,cas_n,we_n}` decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, and anything else is a no-op.
- R2: After reset `dev_state` is 0, and `dq_oe`, `dq_out` and `illegal_cmd` are 0. The state codes are 0 init, 1 idle, 2 refresh, 3 mode set, 4 driver calibration, 5 active, 6 active power-down, 7 writing, 8 reading and 9 precharge.
- R3: In init, only precharge is accepted. Any other command raises `illegal_cmd` and the state stays 0. From idle, activate is refused as illegal until at least one mode register set and one refresh have been seen.
- R4: A mode register set in idle with `ba`=0 loads `addr[6:0]` into the mode register. In that register, bits [2:0]=011 select a burst of 8 and any other code selects a burst of 4. Bit 3 set selects interleaved order. Bits [6:4] give the CAS latency when they are 2 to 6, and any other code means 3. A set with `ba`=1 and a nonzero `addr[9:7]` passes one cycle in state 4, while any other set passes one cycle in state 3. Both then return to idle.
- R5: A refresh holds state 2 for exactly 8 cycles, then returns to idle. Every command that arrives during those cycles is ignored.
- R6: Activate opens the row given on `addr` in bank `ba` and enters state 5. The storage index is `{ba, row fold, column[3:0]}`, where the row fold XORs the 13 row bits into 2 bits (bit i goes into fold bit i mod 2). A write command issued at edge E stores beat k from `dq_in` at edge E+1+k. Beat k uses column `(c & ~m) | ((c+k) & m)` in sequential order or `c ^ k` in interleaved order, where m is the burst length minus 1. The state returns to 5 after the last beat, and commands are ignored during the burst.
- R7: During a write beat, `dm[i]`=1 leaves byte lane i of the addressed word unchanged.
- R8: For a read issued at edge E, beat k (with the R6 column order) is on `dq_out` with `dq_oe`=1 from edge E+CL+k until the next edge. At all other times `dq_oe` is 0 and `dq_out` is 0.
- R9: A read or write with no open row (idle), and an activate, refresh or mode set while a row is open, each raise `illegal_cmd` for one cycle. The state and the storage are left unchanged.
- R10: Precharge passes one cycle in state 9 and then enters idle with the row closed.
- R11: In state 5, `cke` low moves the device to state 6 at the next edge. There it ignores commands until `cke` is high, and then it returns to state 5 with the same row still open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable, low requests power-down |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank address / mode register select |
| addr | input | 13 | Row, column or mode value |
| dm | input | 2 | Per-byte write mask, 1 = keep |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, 0 when idle |
| dq_oe | output | 1 | Read data drive enable |
| illegal_cmd | output | 1 | One-cycle flag for a refused command |
| dev_state | output | 4 | Current device state code |

## Verification
State and flag results are registered once, so the bench samples them at the falling edge that follows the command edge. Refresh exit is checked at the eighth edge after the command, with a command planted in the middle of the window. Write beats are driven one falling edge ahead of edges E+1 through E+burst. Read beats are checked starting at the falling edge after edge E+CL, and the enable is checked low one cycle earlier. This is done for CAS latencies 3, 5 and 3-by-default, both burst lengths and both burst orders. A model array in the bench, updated byte by byte under the mask, supplies the expected read data.

// File: rtl/ddr2dev_pkg.sv
// Package: shared command and state types for the DDR2 device model.
// Assumes: state codes are visible at the top-level port and must stay fixed.
package ddr2dev_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } cmd_e;

    typedef enum logic [3:0] {
        ST_INIT = 4'd0,
        ST_IDLE = 4'd1,
        ST_REF  = 4'd2,
        ST_MRS  = 4'd3,
        ST_OCD  = 4'd4,
        ST_ACT  = 4'd5,
        ST_APD  = 4'd6,
        ST_WR   = 4'd7,
        ST_RD   = 4'd8,
        ST_PRE  = 4'd9
    } state_e;

endpackage

// File: rtl/ddr2dev_cmd_decode.sv
// Module: turns the active-low strobe levels into a command code.
// Assumes: strobes are already stable at the sampling edge; purely combinational.
module ddr2dev_cmd_decode
    import ddr2dev_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Table lookup of the strobe pattern; deselect wins over everything.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr2dev_refresh.sv
// Module: refresh sequencer with an up counter and a backlog counter.
// Assumes: start is a single-cycle pulse issued only when no refresh runs.
module ddr2dev_refresh #(
    parameter int REF_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);

    localparam int CNT_W = $clog2(REF_CYCLES + 1);

    logic [CNT_W-1:0] up_q;
    logic [CNT_W-1:0] backlog_q;

    // Load both counters on start, then step them until the backlog drains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q      <= '0;
            backlog_q <= '0;
        end else if (start) begin
            up_q      <= '0;
            backlog_q <= CNT_W'(REF_CYCLES);
        end else if (backlog_q != '0) begin
            up_q      <= up_q + 1'b1;
            backlog_q <= backlog_q - 1'b1;
        end
    end

    // Final cycle of the refresh window.
    always_comb last = (backlog_q != '0) && (up_q == CNT_W'(REF_CYCLES - 1));

endmodule

// File: rtl/ddr2dev_store.sv
// Module: byte-lane storage array with masked writes and combinational read.
// Assumes: contents are not reset; a write and a read of one index in one cycle
// returns the old word.
module ddr2dev_store #(
    parameter int DW    = 16,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW/8-1:0]  wr_mask,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    localparam int LANES = DW / 8;
    localparam int DEPTH = 1 << IDX_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        // Store this lane's byte unless its mask bit is set.
        always_ff @(posedge clk) begin
            if (wr_en && !wr_mask[l]) begin
                lane_mem[wr_idx] <= wr_data[l*8 +: 8];
            end
        end

        assign rd_data[l*8 +: 8] = lane_mem[rd_idx];
    end

endmodule

// File: rtl/ddr2dev_rd_pipe.sv
// Module: CAS-latency delay line for read beats and the registered data output.
// Assumes: cl_sel = latency - 2 and stays below MAX_CL - 1; data is fetched at
// the tap, one cycle ahead of the output register.
module ddr2dev_rd_pipe #(
    parameter int DW     = 16,
    parameter int IDX_W  = 8,
    parameter int MAX_CL = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             push,
    input  logic [IDX_W-1:0]                 push_idx,
    input  logic [$clog2(MAX_CL-1)-1:0]      cl_sel,
    output logic [IDX_W-1:0]                 tap_idx,
    input  logic [DW-1:0]                    tap_data,
    output logic [DW-1:0]                    dq_out,
    output logic                             dq_oe
);

    localparam int STAGES = MAX_CL - 1;

    logic [STAGES-1:0] vld_w;
    logic [IDX_W-1:0]  idx_w [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic             v_q;
        logic [IDX_W-1:0] i_q;

        if (g == 0) begin : g_head
            // First stage captures the beat issued this cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    i_q <= '0;
                end else begin
                    v_q <= push;
                    i_q <= push_idx;
                end
            end
        end else begin : g_body
            // Later stages shift the beat one cycle further.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= 1'b0;
                    i_q <= '0;
                end else begin
                    v_q <= vld_w[g-1];
                    i_q <= idx_w[g-1];
                end
            end
        end

        assign vld_w[g] = v_q;
        assign idx_w[g] = i_q;
    end

    logic tap_vld;
    always_comb tap_vld = vld_w[cl_sel];
    always_comb tap_idx = idx_w[cl_sel];

    // Drive the beat for one cycle, otherwise park the bus at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            dq_out <= tap_vld ? tap_data : '0;
            dq_oe  <= tap_vld;
        end
    end

endmodule

// File: rtl/ddr2_device_fsm.sv
// Module: top of the DDR2 device model: command FSM, mode register, open row,
// burst sequencing, storage and read latency.
// Assumes: one open row at a time across all banks; single data rate.
module ddr2_device_fsm
    import ddr2dev_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2,
    parameter int DW         = 16,
    parameter int ROW_IDX_W  = 2,
    parameter int COL_IDX_W  = 4,
    parameter int REF_CYCLES = 8,
    parameter int MAX_CL     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BA_W-1:0]   ba,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW/8-1:0]   dm,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe,
    output logic              illegal_cmd,
    output logic [3:0]        dev_state
);

    localparam int IDX_W = BA_W + ROW_IDX_W + COL_IDX_W;
    localparam int MR_W  = 7;
    localparam int SEL_W = $clog2(MAX_CL - 1);
    localparam logic [MR_W-1:0] MR_RESET = 7'b011_0_010;

    cmd_e   cmd;
    state_e state_q, state_nxt;

    logic [MR_W-1:0]      mr_q;
    logic [ROW_IDX_W-1:0] open_row_q;
    logic [BA_W-1:0]      open_bank_q;
    logic [COL_IDX_W-1:0] base_col_q;
    logic [2:0]           beat_q;
    logic                 mrs_seen_q, ref_seen_q, illegal_q;

    logic ld_row, ld_mr, start_ref, start_burst, set_mrs, illegal_nxt;
    logic ref_last;

    // Decode the sampled strobes.
    ddr2dev_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    // Refresh window timing.
    ddr2dev_refresh #(.REF_CYCLES(REF_CYCLES)) u_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_ref),
        .last (ref_last)
    );

    // Fold every row address bit into the small row index.
    function automatic logic [ROW_IDX_W-1:0] fold_row(input logic [ADDR_W-1:0] a);
        logic [ROW_IDX_W-1:0] f;
        f = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            f[i % ROW_IDX_W] = f[i % ROW_IDX_W] ^ a[i];
        end
        return f;
    endfunction

    // Mode register field decode.
    logic [2:0]       bl_mask;
    logic             interleave;
    logic [2:0]       cl_eff;
    logic [SEL_W-1:0] cl_sel;
    always_comb begin
        bl_mask    = (mr_q[2:0] == 3'b011) ? 3'd7 : 3'd3;
        interleave = mr_q[3];
        cl_eff     = (mr_q[6:4] >= 3'd2 && 32'(mr_q[6:4]) <= MAX_CL) ? mr_q[6:4] : 3'd3;
        cl_sel     = SEL_W'(cl_eff - 3'd2);
    end

    // Column of the current beat in the selected burst order.
    logic [COL_IDX_W-1:0] bmask, kx, col_now;
    always_comb begin
        bmask = COL_IDX_W'(bl_mask);
        kx    = COL_IDX_W'(beat_q);
        if (interleave) begin
            col_now = base_col_q ^ kx;
        end else begin
            col_now = (base_col_q & ~bmask) | ((base_col_q + kx) & bmask);
        end
    end

    logic [IDX_W-1:0] beat_idx;
    always_comb beat_idx = {open_bank_q, open_row_q, col_now};

    // Next-state and command acceptance rules.
    always_comb begin
        state_nxt   = state_q;
        illegal_nxt = 1'b0;
        ld_row      = 1'b0;
        ld_mr       = 1'b0;
        start_ref   = 1'b0;
        start_burst = 1'b0;
        set_mrs     = 1'b0;
        case (state_q)
            ST_INIT: begin
                if (cmd == CMD_PRE)      state_nxt   = ST_PRE;
                else if (cmd != CMD_NOP) illegal_nxt = 1'b1;
            end
            ST_IDLE: begin
                case (cmd)
                    CMD_ACT: begin
                        if (mrs_seen_q && ref_seen_q) begin
                            state_nxt = ST_ACT;
                            ld_row    = 1'b1;
                        end else begin
                            illegal_nxt = 1'b1;
                        end
                    end
                    CMD_REF: begin
                        state_nxt = ST_REF;
                        start_ref = 1'b1;
                    end
                    CMD_MRS: begin
                        set_mrs = 1'b1;
                        if (ba == BA_W'(0)) ld_mr = 1'b1;
                        if (ba == BA_W'(1) && addr[9:7] != 3'b000) state_nxt = ST_OCD;
                        else                                        state_nxt = ST_MRS;
                    end
                    CMD_PRE:         state_nxt   = ST_PRE;
                    CMD_RD, CMD_WR:  illegal_nxt = 1'b1;
                    default:         ;
                endcase
            end
            ST_REF: begin
                if (ref_last) state_nxt = ST_IDLE;
            end
            ST_MRS, ST_OCD, ST_PRE: state_nxt = ST_IDLE;
            ST_ACT: begin
                if (!cke) begin
                    state_nxt = ST_APD;
                end else begin
                    case (cmd)
                        CMD_RD: begin
                            state_nxt   = ST_RD;
                            start_burst = 1'b1;
                        end
                        CMD_WR: begin
                            state_nxt   = ST_WR;
                            start_burst = 1'b1;
                        end
                        CMD_PRE:                   state_nxt   = ST_PRE;
                        CMD_ACT, CMD_REF, CMD_MRS: illegal_nxt = 1'b1;
                        default:                   ;
                    endcase
                end
            end
            ST_APD: begin
                if (cke) state_nxt = ST_ACT;
            end
            ST_WR, ST_RD: begin
                if (beat_q == bl_mask) state_nxt = ST_ACT;
            end
            default: state_nxt = ST_INIT;
        endcase
    end

    // State, flags and mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_INIT;
            mr_q       <= MR_RESET;
            mrs_seen_q <= 1'b0;
            ref_seen_q <= 1'b0;
            illegal_q  <= 1'b0;
        end else begin
            state_q   <= state_nxt;
            illegal_q <= illegal_nxt;
            if (ld_mr)     mr_q       <= addr[MR_W-1:0];
            if (set_mrs)   mrs_seen_q <= 1'b1;
            if (start_ref) ref_seen_q <= 1'b1;
        end
    end

    // Open row, burst start column and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row_q  <= '0;
            open_bank_q <= '0;
            base_col_q  <= '0;
            beat_q      <= '0;
        end else begin
            if (ld_row) begin
                open_row_q  <= fold_row(addr);
                open_bank_q <= ba;
            end
            if (start_burst) begin
                base_col_q <= addr[COL_IDX_W-1:0];
                beat_q     <= '0;
            end else if (state_q == ST_WR || state_q == ST_RD) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    logic [IDX_W-1:0] tap_idx;
    logic [DW-1:0]    tap_data;

    // Backing storage.
    ddr2dev_store #(.DW(DW), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .wr_en  (state_q == ST_WR),
        .wr_idx (beat_idx),
        .wr_data(dq_in),
        .wr_mask(dm),
        .rd_idx (tap_idx),
        .rd_data(tap_data)
    );

    // Read latency line and output register.
    ddr2dev_rd_pipe #(.DW(DW), .IDX_W(IDX_W), .MAX_CL(MAX_CL)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (state_q == ST_RD),
        .push_idx(beat_idx),
        .cl_sel  (cl_sel),
        .tap_idx (tap_idx),
        .tap_data(tap_data),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    assign illegal_cmd = illegal_q;
    assign dev_state   = state_q;

endmodule

// File: rtl/ddr2dev_checker.sv
// Module: property checker for the DDR2 device model, bound to its top.
// Assumes: observes top-level ports only; counts the refresh window itself.
module ddr2dev_checker
    import ddr2dev_pkg::*;
#(
    parameter int REF_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       illegal_cmd,
    input logic       dq_oe,
    input logic [3:0] dev_state
);

    logic [7:0] ref_run;

    // Count consecutive cycles spent in refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ref_run <= '0;
        else if (dev_state == ST_REF) ref_run <= ref_run + 1'b1;
        else                        ref_run <= '0;
    end

    a_r2_state_code: assert property (@(posedge clk) disable iff (!rst_n)
        dev_state <= 4'd9);

    a_r2_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state == ST_INIT) |-> !dq_oe);

    a_r5_refresh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state == ST_REF && 32'(ref_run) < REF_CYCLES - 1) |=> dev_state == ST_REF);

    a_r5_refresh_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state == ST_REF && 32'(ref_run) == REF_CYCLES - 1) |=> dev_state == ST_IDLE);

    a_r6_write_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state != ST_ACT && dev_state != ST_WR) |=> dev_state != ST_WR);

    a_r8_read_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state != ST_ACT && dev_state != ST_RD) |=> dev_state != ST_RD);

    a_r9_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cmd |-> dev_state == $past(dev_state));

    a_r11_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state == ST_APD && !cke) |=> dev_state == ST_APD);

    a_r11_pd_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_state == ST_APD && cke) |=> dev_state == ST_ACT);

endmodule

bind ddr2_device_fsm ddr2dev_checker #(.REF_CYCLES(REF_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .illegal_cmd(illegal_cmd),
    .dq_oe      (dq_oe),
    .dev_state  (dev_state)
);

// File: tb/sim_ddr2_device_fsm.sv
// Directed bench for the DDR2 device model; one task per scenario.
module sim_ddr2_device_fsm;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] P_NOP = 4'b1111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [1:0]  dm = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe, illegal_cmd;
    logic [3:0]  dev_state;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2_device_fsm u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dm(dm),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .illegal_cmd(illegal_cmd), .dev_state(dev_state)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] model [256];
    int cur_bl = 4, cur_cl = 3, cur_bank = 0, cur_row = 0;
    bit cur_ilv = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fold(input int row);
        int f = 0;
        for (int i = 0; i < 13; i++) f = f ^ (((row >> i) & 1) << (i % 2));
        return f;
    endfunction

    function automatic int beat_col(input int c, input int k);
        int m = cur_bl - 1;
        if (cur_ilv) return (c ^ k) & 15;
        return ((c & ~m) | ((c + k) & m)) & 15;
    endfunction

    function automatic int mem_idx(input int col);
        return (cur_bank << 6) | (fold(cur_row) << 4) | (col & 15);
    endfunction

    // Drive one command for one edge; returns at the falling edge after it.
    task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic [12:0] a);
        {cs_n, ras_n, cas_n, we_n} = p;
        ba = b;
        addr = a;
        @(posedge clk);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
    endtask

    task automatic t_reset();
        chk("R2 state after reset", dev_state, 0);
        chk("R2 oe after reset", dq_oe, 0);
        chk("R2 dq_out after reset", dq_out, 0);
        chk("R2 illegal after reset", illegal_cmd, 0);
    endtask

    task automatic t_init();
        issue(P_ACT, 0, 0);
        chk("R3 act in init flagged", illegal_cmd, 1);
        chk("R3 init state kept", dev_state, 0);
        @(negedge clk);
        chk("R9 flag lasts one cycle", illegal_cmd, 0);
        issue(P_PRE, 0, 13'h400);
        chk("R10 init precharge state", dev_state, 9);
        @(negedge clk);
        chk("R10 precharge to idle", dev_state, 1);
        issue(P_ACT, 0, 0);
        chk("R3 act before setup flagged", illegal_cmd, 1);
        chk("R3 act before setup state", dev_state, 1);
        issue(P_RD, 0, 0);
        chk("R9 read with no row flagged", illegal_cmd, 1);
        // R1: deselected MRS pattern is a no-op
        {cs_n, ras_n, cas_n, we_n} = 4'b1000;
        @(posedge clk);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
        chk("R1 cs high ignored", dev_state, 1);
        chk("R1 cs high no flag", illegal_cmd, 0);
    endtask

    task automatic t_mrs(input logic [12:0] val);
        issue(P_MRS, 0, val);
        chk("R4 mode set state", dev_state, 3);
        @(negedge clk);
        chk("R4 mode set back to idle", dev_state, 1);
        cur_bl  = (val[2:0] == 3'b011) ? 8 : 4;
        cur_ilv = val[3];
        cur_cl  = (val[6:4] >= 2 && val[6:4] <= 6) ? int'(val[6:4]) : 3;
    endtask

    task automatic t_ocd();
        issue(P_MRS, 1, 13'h380);
        chk("R4 calibration state", dev_state, 4);
        @(negedge clk);
        chk("R4 calibration back to idle", dev_state, 1);
        issue(P_MRS, 1, 13'h004);
        chk("R4 plain extended set", dev_state, 3);
        @(negedge clk);
    endtask

    task automatic t_refresh();
        issue(P_REF, 0, 0);
        chk("R5 refresh entered", dev_state, 2);
        for (int i = 1; i < 8; i++) begin
            if (i == 3) {cs_n, ras_n, cas_n, we_n} = P_ACT;
            @(posedge clk);
            @(negedge clk);
            {cs_n, ras_n, cas_n, we_n} = P_NOP;
            chk("R5 refresh held", dev_state, 2);
        end
        @(negedge clk);
        chk("R5 refresh exit to idle", dev_state, 1);
        chk("R5 command ignored no flag", illegal_cmd, 0);
    endtask

    task automatic t_activate(input int b, input int row);
        issue(P_ACT, b[1:0], row[12:0]);
        chk("R6 activate state", dev_state, 5);
        cur_bank = b;
        cur_row  = row;
    endtask

    task automatic t_write(input int col, input logic [15:0] base, input logic [1:0] mask1);
        issue(P_WR, cur_bank[1:0], col[12:0]);
        chk("R6 writing state", dev_state, 7);
        for (int k = 0; k < cur_bl; k++) begin
            int ix = mem_idx(beat_col(col, k));
            logic [15:0] d = base + 16'(k * 16'h0111);
            dq_in = d;
            dm = (k == 1) ? mask1 : 2'b00;
            if (!dm[0]) model[ix][7:0]  = d[7:0];
            if (!dm[1]) model[ix][15:8] = d[15:8];
            @(negedge clk);
        end
        dm = 2'b00;
        chk("R6 write burst back to active", dev_state, 5);
    endtask

    task automatic t_read(input int col);
        issue(P_RD, cur_bank[1:0], col[12:0]);
        repeat (cur_cl - 1) @(negedge clk);
        chk("R8 bus released before latency", dq_oe, 0);
        for (int k = 0; k < cur_bl; k++) begin
            @(negedge clk);
            chk("R8 read beat enable", dq_oe, 1);
            chk("R8 R7 read beat data", dq_out, model[mem_idx(beat_col(col, k))]);
        end
        @(negedge clk);
        chk("R8 bus released after burst", dq_oe, 0);
        chk("R8 bus parked zero", dq_out, 0);
    endtask

    task automatic t_illegal_open();
        issue(P_REF, 0, 0);
        chk("R9 refresh with open row flagged", illegal_cmd, 1);
        chk("R9 refresh with open row state", dev_state, 5);
    endtask

    task automatic t_precharge();
        issue(P_PRE, 0, 13'h400);
        chk("R10 precharge state", dev_state, 9);
        @(negedge clk);
        chk("R10 row closed idle", dev_state, 1);
        issue(P_WR, 0, 0);
        chk("R9 write with no row flagged", illegal_cmd, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9 no data after refused write", dq_oe, 0);
        end
        chk("R9 idle after refused write", dev_state, 1);
    endtask

    task automatic t_powerdown();
        cke = 1'b0;
        @(negedge clk);
        chk("R11 power-down entered", dev_state, 6);
        issue(P_PRE, 0, 13'h400);
        chk("R11 command ignored in power-down", dev_state, 6);
        cke = 1'b1;
        @(negedge clk);
        chk("R11 back to active", dev_state, 5);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_init();
        t_mrs(13'h032);
        t_ocd();
        t_refresh();
        t_activate(2, 1);
        t_illegal_open();
        t_write(0, 16'hA000, 2'b00);
        t_write(1, 16'h5B00, 2'b01);
        t_write(4, 16'h3C00, 2'b10);
        t_read(0);
        t_read(6);
        t_precharge();
        t_mrs(13'h05B);
        t_activate(1, 2);
        t_write(3, 16'hC100, 2'b11);
        t_read(5);
        t_powerdown();
        t_read(0);
        t_precharge();
        t_mrs(13'h072);
        t_activate(1, 2);
        t_read(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule